// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked Register Writes

This block is one port of general-purpose I/O: eight pins, each with a mode bit, a direction bit and a drive-value bit, plus a read-only view of the pad levels. Software reaches it over a simple synchronous register bus. There is no read strobe. Read data is a combinational function of the address and of the register state. A write is captured on the rising clock edge while the write strobe is high.

Each writable register can be reached at two addresses. A direct write replaces all eight bits. The masked alias sits at a fixed alias offset above the direct register and keeps the same spacing. Its upper write byte marks which pins take the value in the lower byte, so one pin can change without a read-modify-write sequence. A pin whose mode bit is clear belongs to some other function. Such a pin never drives its pad from this port. A pin in GPIO mode drives its pad only when its direction bit is set.

Address map with default parameters. Mode is at 0x00 and its masked alias at 0x80. Direction is at 0x10 and its alias at 0x90. Drive value is at 0x20 and its alias at 0xA0. Pad input is at 0x30 and has no alias. The port has no internal sequencing. Its only states are the register contents and the two synchronizer stages.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low, the mode, direction and drive-value registers clear to 0 and so do both synchronizer stages. After reset every register reads 0 and pad_oe and pad_out are 0.
- R2: A write to 0x00, 0x10 or 0x20 loads bits 7:0 into all eight bits of that register. Bits 15:8 of the write data are ignored.
- R3: A write to alias 0x80, 0x90 or 0xA0 updates only the pins whose bit in 15:8 is 1. Pin i takes bit i of the write data. Every other pin keeps its value.
- R4: A masked write whose bits 15:8 are all 0 leaves the target register unchanged.
- R5: pad_oe[i] is 1 exactly when the mode bit and the direction bit of pin i are both 1. It changes only on the edge that captures a register write.
- R6: pad_out carries the drive-value register. It changes only on the edge that captures a register write.
- R7: A read of 0x30 returns in bits 7:0 the pad_in value sampled two rising edges earlier, through a two-flop synchronizer.
- R8: Writes to 0x30 and to unmapped addresses change no register. Reads of unmapped addresses return 0.
- R9: A read of an alias address returns the register it aliases in bits 7:0. On every read, bits 15:8 are 0.
- R10: Reading any address changes no register, pad output or later read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 16 | Write data: pin enables in 15:8, values in 7:0 |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| pad_in | input | 8 | Pad levels, asynchronous to clk |
| pad_out | output | 8 | Drive value for each pad |
| pad_oe | output | 8 | Pad drive enable for each pin |

## Verification
A register write becomes visible on bus_rdata, pad_out and pad_oe right after the single rising edge that captures it. A pad_in change shows at 0x30 only after the second edge. The bench changes its inputs on falling edges and samples one time unit later. A write check therefore always looks after exactly one capturing edge. The synchronizer check looks after zero, one and two edges, so an early or late result is caught.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_STRIDE = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DIR,
        SEL_DRV,
        SEL_PADS
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int                PINS      = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] ALIAS_OFS = 12'h080
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2*PINS-1:0] wdata,
    input  logic              we,
    output reg_sel_e          sel,
    output logic              aliased,
    output logic [PINS-1:0]   upd_mode,
    output logic [PINS-1:0]   upd_dir,
    output logic [PINS-1:0]   upd_drv,
    output logic [PINS-1:0]   new_val
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(REG_STRIDE);
    localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(2*REG_STRIDE);
    localparam logic [ADDR_W-1:0] A_PADS = ADDR_W'(3*REG_STRIDE);

    logic [PINS-1:0] pin_en;

    always_comb begin
        sel     = SEL_NONE;
        aliased = 1'b0;
        if      (addr == A_MODE)             sel = SEL_MODE;
        else if (addr == A_DIR)              sel = SEL_DIR;
        else if (addr == A_DRV)              sel = SEL_DRV;
        else if (addr == A_PADS)             sel = SEL_PADS;
        else if (addr == ALIAS_OFS + A_MODE) begin sel = SEL_MODE; aliased = 1'b1; end
        else if (addr == ALIAS_OFS + A_DIR)  begin sel = SEL_DIR;  aliased = 1'b1; end
        else if (addr == ALIAS_OFS + A_DRV)  begin sel = SEL_DRV;  aliased = 1'b1; end
    end

    always_comb begin
        pin_en   = aliased ? wdata[2*PINS-1:PINS] : {PINS{1'b1}};
        new_val  = wdata[PINS-1:0];
        upd_mode = (we && sel == SEL_MODE) ? pin_en : '0;
        upd_dir  = (we && sel == SEL_DIR)  ? pin_en : '0;
        upd_drv  = (we && sel == SEL_DRV)  ? pin_en : '0;
    end

endmodule

// File: rtl/gpio_pin_reg.sv
module gpio_pin_reg #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] upd,
    input  logic [PINS-1:0] new_val,
    output logic [PINS-1:0] q
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (upd[i]) q[i] <= new_val[i];
        end

        p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
            upd[i] |=> q[i] == $past(new_val[i]));

        p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !upd[i] |=> $stable(q[i]));
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_sync
);
    logic [PINS-1:0] stage1;
    logic [1:0]      live_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            pad_sync <= '0;
        end else begin
            stage1   <= pad_in;
            pad_sync <= stage1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              live_cnt <= 2'd0;
        else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
    end

    p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2) |-> pad_sync == $past(pad_in, 2));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int                PINS      = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] ALIAS_OFS = 12'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2*PINS-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [2*PINS-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    reg_sel_e        sel;
    logic            aliased;
    logic [PINS-1:0] upd_mode, upd_dir, upd_drv, new_val;
    logic [PINS-1:0] mode_q, dir_q, drv_q, pads_q;
    logic [PINS-1:0] rd_val;

    gpio_addr_dec #(.PINS(PINS), .ADDR_W(ADDR_W), .ALIAS_OFS(ALIAS_OFS)) u_dec (
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .sel      (sel),
        .aliased  (aliased),
        .upd_mode (upd_mode),
        .upd_dir  (upd_dir),
        .upd_drv  (upd_drv),
        .new_val  (new_val)
    );

    gpio_pin_reg #(.PINS(PINS)) u_mode (
        .clk(clk), .rst_n(rst_n), .upd(upd_mode), .new_val(new_val), .q(mode_q));
    gpio_pin_reg #(.PINS(PINS)) u_dir (
        .clk(clk), .rst_n(rst_n), .upd(upd_dir), .new_val(new_val), .q(dir_q));
    gpio_pin_reg #(.PINS(PINS)) u_drv (
        .clk(clk), .rst_n(rst_n), .upd(upd_drv), .new_val(new_val), .q(drv_q));

    gpio_in_sync #(.PINS(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_sync(pads_q));

    always_comb begin
        unique case (sel)
            SEL_MODE: rd_val = mode_q;
            SEL_DIR:  rd_val = dir_q;
            SEL_DRV:  rd_val = drv_q;
            SEL_PADS: rd_val = pads_q;
            default:  rd_val = '0;
        endcase
    end

    assign bus_rdata = {{PINS{1'b0}}, rd_val};
    assign pad_oe    = mode_q & dir_q;
    assign pad_out   = drv_q;

    p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|upd_mode, |upd_dir, |upd_drv}));

    p_pads_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PADS) |-> (upd_mode == '0 && upd_dir == '0 && upd_drv == '0));

    p_oe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_oe));

    p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_out));

    p_alias_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        aliased |-> bus_rdata[2*PINS-1:PINS] == '0);

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int CLK_P = 10;
    localparam int NV    = 14;

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [15:0] wd;
        logic [11:0] ra;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Rows run in order from the reset state.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h000, 16'hFFA5, 12'h000, 16'h00A5, 8'd2},  // R2 upper byte ignored
        '{1'b1, 12'h010, 16'h000F, 12'h010, 16'h000F, 8'd2},  // R2
        '{1'b1, 12'h020, 16'h003C, 12'h020, 16'h003C, 8'd2},  // R2
        '{1'b1, 12'h080, 16'h0F0A, 12'h000, 16'h00AA, 8'd3},  // R3 low nibble only
        '{1'b1, 12'h090, 16'hF0FF, 12'h010, 16'h00FF, 8'd3},  // R3 high nibble only
        '{1'b1, 12'h0A0, 16'h8181, 12'h020, 16'h00BD, 8'd3},  // R3 pins 7 and 0
        '{1'b1, 12'h0A0, 16'h0055, 12'h020, 16'h00BD, 8'd4},  // R4 empty mask
        '{1'b1, 12'h030, 16'hFFFF, 12'h020, 16'h00BD, 8'd8},  // R8 write to input
        '{1'b1, 12'h030, 16'hFFFF, 12'h000, 16'h00AA, 8'd8},  // R8
        '{1'b1, 12'h044, 16'hFFFF, 12'h044, 16'h0000, 8'd8},  // R8 unmapped
        '{1'b1, 12'h090, 16'h0100, 12'h010, 16'h00FE, 8'd3},  // R3 clear pin 0
        '{1'b0, 12'h000, 16'h0000, 12'h0A0, 16'h00BD, 8'd9},  // R9 alias read
        '{1'b0, 12'h000, 16'h0000, 12'h080, 16'h00AA, 8'd9},  // R9
        '{1'b0, 12'h000, 16'h0000, 12'h090, 16'h00FE, 8'd9}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_chk(input int req, input logic [11:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_chk(1, 12'h000, 16'h0000);
        read_chk(1, 12'h010, 16'h0000);
        read_chk(1, 12'h020, 16'h0000);
        read_chk(1, 12'h030, 16'h0000);
        check(1, {8'h00, pad_oe}, 16'h0000);
        check(1, {8'h00, pad_out}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) bus_write(VEC[i].addr, VEC[i].wd);
            else @(negedge clk);
            read_chk(int'(VEC[i].req), VEC[i].ra, VEC[i].exp);
        end

        // R5 / R6: mode AA & direction FE, drive BD
        check(5, {8'h00, pad_oe}, 16'h00AA);
        check(6, {8'h00, pad_out}, 16'h00BD);
        bus_write(12'h080, 16'hFF00);  // all pins to non-GPIO mode
        #1;
        check(5, {8'h00, pad_oe}, 16'h0000);
        check(6, {8'h00, pad_out}, 16'h00BD);
        bus_write(12'h000, 16'h000F);
        #1;
        check(5, {8'h00, pad_oe}, 16'h000E);

        // R7 two-edge synchronizer latency
        @(negedge clk);
        pad_in = 8'h5A;
        read_chk(7, 12'h030, 16'h0000);
        @(negedge clk);
        read_chk(7, 12'h030, 16'h0000);
        @(negedge clk);
        read_chk(7, 12'h030, 16'h005A);

        // R10 repeated reads leave state alone
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            read_chk(10, 12'h030, 16'h005A);
        end
        read_chk(10, 12'h020, 16'h00BD);
        check(10, {8'h00, pad_oe}, 16'h000E);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(1, 12'h000, 16'h0000);
        read_chk(1, 12'h020, 16'h0000);
        read_chk(1, 12'h030, 16'h0000);
        check(1, {8'h00, pad_oe}, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule